// File: doc/BRIEF.md
# Paged EEPROM Array Controller

This block sits behind a two-wire slave front-end and owns the storage side of a small serial EEPROM: a 256-byte array, an 8-bit word pointer and a 16-byte page staging buffer. The front-end decodes the bus. It hands this block one-cycle event pulses: a command with its direction bit, a received byte, START, STOP, and a request for the next outgoing read byte. The block answers with a command acknowledge, read data and a busy flag.

The first byte of a write command loads the word pointer. The upper four bits select the row (page) and the lower four the column. Later bytes are staged at the current column, and only the column advances, wrapping within the row. A STOP after at least one staged byte starts a self-timed programming window of `PROG_CYCLES` clocks, unless write protect is high. During that window the staged bytes are committed to the array, busy is high, and every input event is ignored. Reads return the byte at the pointer and then advance it across the whole array. Sending a write command that carries only a word address, followed by a read command, gives a random read.

The controller has five states. `ST_IDLE` is standby. `ST_GET_ADDR` waits for the word address. `ST_LOAD` stages data bytes. `ST_READ` serves read requests. `ST_PROG` is the busy window. The transitions are as follows:
- IDLE→GET_ADDR on an accepted write command, and IDLE→READ on an accepted read command.
- GET_ADDR→LOAD on a byte.
- LOAD→PROG on a STOP with staged bytes and write protect low.
- LOAD→IDLE on any other STOP, or on a START.
- GET_ADDR or READ→IDLE on a START or STOP.
- Any non-busy state →GET_ADDR or →READ on a new command, which acts as a repeated start.
- PROG→IDLE when the timer expires.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, busy, cmd_ack and rd_valid are low, every array byte reads 0xFF, and the word pointer is 0.
- R2: A command pulse while not busy gives cmd_ack high for exactly the following cycle. A write command (cmd_rd=0) expects a word address, and a read command (cmd_rd=1) serves reads.
- R3: The first byte of a write command sets the word pointer. Each data byte is staged at pointer bits [3:0], after which only those bits increment, wrapping from 15 to 0 with bits [7:4] unchanged.
- R4: When more than 16 data bytes are sent, a byte overwrites the earlier byte staged at the same column. Only staged columns are programmed, and the other bytes of the row keep their values.
- R5: A STOP after at least one data byte, with wp low, raises busy in the next cycle for exactly PROG_CYCLES cycles. After that, the array holds the staged bytes.
- R6: A STOP that follows only the word address starts no busy window and changes no array byte.
- R7: With wp high at STOP, no busy window starts and no array byte changes. Reads work normally.
- R8: While busy is high, commands get no acknowledge, and bytes, STOPs and read requests have no effect on the array, the pointer or rd_valid.
- R9: In the read state, a read request gives rd_valid high in the next cycle with the byte at the pointer, and then increments the pointer, wrapping from 255 to 0.
- R10: After a write, the pointer equals the row of the word address joined with the column after the last staged byte.
- R11: A write command carrying only a word address, followed by a read command, reads from that address and programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_cmd | input | 1 | Address-matched command pulse |
| ev_cmd_rd | input | 1 | Direction of the command, 1 = read |
| ev_byte | input | 1 | Received byte pulse |
| ev_data | input | 8 | Received byte value |
| ev_start | input | 1 | START seen on the bus |
| ev_stop | input | 1 | STOP seen on the bus |
| rd_req | input | 1 | Front-end asks for the next read byte |
| wp | input | 1 | Write protect, high blocks programming |
| cmd_ack | output | 1 | Command accepted, one-cycle pulse |
| rd_valid | output | 1 | rd_data holds a fresh byte |
| rd_data | output | 8 | Byte read from the array |
| busy | output | 1 | Self-timed programming in progress |

## Verification
A corrupted word pointer shows up on the first read byte after the write or read that disturbed it, because every later read is compared with a pointer model in the bench. A wrong staging column or a stray commit appears as a wrong value the next time that row is read. Random transfers revisit rows often, so such an error is usually caught within a few transactions. A timer or state fault shows up at once as a busy window of the wrong length, or as an acknowledge given while busy.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_ADDR,
        ST_LOAD,
        ST_READ,
        ST_PROG
    } ctrl_state_t;

endpackage

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array #(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  ERASED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(ERASED);
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_page_latch.sv
module eeprom_page_latch #(
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ld_en,
    input  logic [COL_W-1:0] ld_col,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [COL_W-1:0] rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic             rd_loaded,
    output logic             any_loaded
);
    localparam int PAGE_BYTES = 1 << COL_W;

    logic [DATA_W-1:0]     slots [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[g]  <= '0;
                loaded[g] <= 1'b0;
            end else if (clear) begin
                loaded[g] <= 1'b0;
            end else if (ld_en && (ld_col == COL_W'(g))) begin
                slots[g]  <= ld_data;
                loaded[g] <= 1'b1;
            end
        end
    end

    assign rd_data    = slots[rd_col];
    assign rd_loaded  = loaded[rd_col];
    assign any_loaded = |loaded;
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
    parameter int PROG_CYCLES = 1000000,
    parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    assign last = (cnt == CNT_W'(PROG_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!last) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
    parameter int         ADDR_W      = 8,
    parameter int         COL_W       = 4,
    parameter int         DATA_W      = 8,
    parameter int         PROG_CYCLES = 1000000,
    parameter logic [7:0] ERASED      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cmd,
    input  logic              ev_cmd_rd,
    input  logic              ev_byte,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              rd_req,
    input  logic              wp,
    output logic              cmd_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    import eeprom_pkg::*;

    localparam int ROW_W      = ADDR_W - COL_W;
    localparam int PAGE_BYTES = 1 << COL_W;
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

    ctrl_state_t state, state_nxt;

    logic [ADDR_W-1:0] ptr;
    logic [ROW_W-1:0]  ptr_row;
    logic [COL_W-1:0]  ptr_col;
    logic              quiet;
    logic              cmd_taken;
    logic              ld_en;
    logic              latch_clear;
    logic [DATA_W-1:0] latch_q;
    logic              latch_hit;
    logic              latch_any;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_last;
    logic              in_prog;
    logic [COL_W-1:0]  commit_col;
    logic              commit_en;
    logic [DATA_W-1:0] mem_q;

    assign ptr_row    = ptr[ADDR_W-1:COL_W];
    assign ptr_col    = ptr[COL_W-1:0];
    assign in_prog    = (state == ST_PROG);
    assign quiet      = !ev_cmd && !ev_start && !ev_stop;
    assign cmd_taken  = ev_cmd && !in_prog;
    assign ld_en      = (state == ST_LOAD) && ev_byte && quiet;
    assign latch_clear = cmd_taken && !ev_cmd_rd;
    assign commit_col = tmr_cnt[COL_W-1:0];
    assign commit_en  = in_prog && (tmr_cnt < CNT_W'(PAGE_BYTES)) && latch_hit;

    eeprom_page_latch #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (latch_clear),
        .ld_en      (ld_en),
        .ld_col     (ptr_col),
        .ld_data    (ev_data),
        .rd_col     (commit_col),
        .rd_data    (latch_q),
        .rd_loaded  (latch_hit),
        .any_loaded (latch_any)
    );

    eeprom_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_prog),
        .cnt   (tmr_cnt),
        .last  (tmr_last)
    );

    eeprom_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ERASED (ERASED)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_addr ({ptr_row, commit_col}),
        .wr_data (latch_q),
        .rd_addr (ptr),
        .rd_data (mem_q)
    );

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PROG: begin
                if (tmr_last) state_nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (ev_cmd) state_nxt = ev_cmd_rd ? ST_READ : ST_GET_ADDR;
            end
            ST_GET_ADDR: begin
                if (ev_cmd)                   state_nxt = ev_cmd_rd ? ST_READ : ST_GET_ADDR;
                else if (ev_start || ev_stop) state_nxt = ST_IDLE;
                else if (ev_byte)             state_nxt = ST_LOAD;
            end
            ST_LOAD: begin
                if (ev_cmd)        state_nxt = ev_cmd_rd ? ST_READ : ST_GET_ADDR;
                else if (ev_start) state_nxt = ST_IDLE;
                else if (ev_stop)  state_nxt = (latch_any && !wp) ? ST_PROG : ST_IDLE;
            end
            ST_READ: begin
                if (ev_cmd)                   state_nxt = ev_cmd_rd ? ST_READ : ST_GET_ADDR;
                else if (ev_start || ev_stop) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Word pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (quiet) begin
            if ((state == ST_GET_ADDR) && ev_byte) begin
                ptr <= ev_data[ADDR_W-1:0];
            end else if (ld_en) begin
                ptr <= {ptr_row, ptr_col + 1'b1};
            end else if ((state == ST_READ) && rd_req) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_ack  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            cmd_ack  <= cmd_taken;
            rd_valid <= (state == ST_READ) && rd_req && quiet;
            if ((state == ST_READ) && rd_req && quiet) rd_data <= mem_q;
        end
    end

    assign busy = in_prog;
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk #(
    parameter int PROG_CYCLES = 1000000
) (
    input logic clk,
    input logic rst_n,
    input logic ev_cmd,
    input logic ev_stop,
    input logic rd_req,
    input logic wp,
    input logic busy,
    input logic cmd_ack,
    input logic rd_valid
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R2
    ack_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd && !busy) |=> cmd_ack);

    // R2
    ack_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> $past(ev_cmd));

    // R8
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd && busy) |=> !cmd_ack);

    // R9
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req) && !$past(busy)));

    // R7
    wp_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && wp && !busy) |=> !busy);

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < PROG_CYCLES));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == PROG_CYCLES));
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_cmd   (ev_cmd),
    .ev_stop  (ev_stop),
    .rd_req   (rd_req),
    .wp       (wp),
    .busy     (busy),
    .cmd_ack  (cmd_ack),
    .rd_valid (rd_valid)
);

// File: tb/tb_eeprom_page_ctrl.sv
module tb_eeprom_page_ctrl;
    localparam int P = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_cmd = 1'b0, ev_cmd_rd = 1'b0, ev_byte = 1'b0;
    logic [7:0] ev_data = '0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, rd_req = 1'b0, wp = 1'b0;
    logic       cmd_ack, rd_valid, busy;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;

    eeprom_page_ctrl #(.PROG_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .ev_cmd(ev_cmd), .ev_cmd_rd(ev_cmd_rd),
        .ev_byte(ev_byte), .ev_data(ev_data), .ev_start(ev_start),
        .ev_stop(ev_stop), .rd_req(rd_req), .wp(wp), .cmd_ack(cmd_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input bit rd, input bit exp_ack);
        @(negedge clk); ev_cmd = 1'b1; ev_cmd_rd = rd;
        @(negedge clk); ev_cmd = 1'b0;
        chk(cmd_ack == exp_ack, exp_ack ? "R2 ack" : "R8 no ack", int'(cmd_ack), int'(exp_ack));
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); ev_byte = 1'b1; ev_data = d;
        @(negedge clk); ev_byte = 1'b0;
    endtask

    task automatic send_stop(input bit w);
        @(negedge clk); ev_stop = 1'b1; wp = w;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic read_one(input string req);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk(rd_valid === 1'b1, req, int'(rd_valid), 1);
        chk(rd_data === ref_mem[ref_ptr], req, int'(rd_data), int'(ref_mem[ref_ptr]));
        ref_ptr = ref_ptr + 8'd1;
    endtask

    task automatic wait_prog(input int exp_len, input string req);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_len, req, n, exp_len);
    endtask

    // Write of n bytes from start address; ignores=1 injects events while busy
    task automatic do_write(input logic [7:0] a, input int n, input bit w, input bit ignores);
        logic [7:0] stage [16];
        bit [15:0]  mask = '0;
        logic [7:0] p;
        send_cmd(1'b0, 1'b1);
        send_byte(a);
        p = a;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            send_byte(d);
            stage[p[3:0]] = d;
            mask[p[3:0]] = 1'b1;
            p = {p[7:4], p[3:0] + 4'd1};
        end
        send_stop(w);
        if (n > 0 && !w) begin
            chk(busy == 1'b1, "R5 busy rises", int'(busy), 1);
            if (ignores) begin
                send_cmd(1'b1, 1'b0);
                send_byte(8'h5A);
                @(negedge clk); rd_req = 1'b1; ev_stop = 1'b1;
                @(negedge clk); rd_req = 1'b0; ev_stop = 1'b0;
                chk(rd_valid == 1'b0, "R8 rd ignored", int'(rd_valid), 0);
                wait_prog(P - 6, "R5 busy length");
            end else begin
                wait_prog(P, "R5 busy length");
            end
            for (int c = 0; c < 16; c++)
                if (mask[c]) ref_mem[{a[7:4], 4'(c)}] = stage[c];
        end else begin
            chk(busy == 1'b0, w ? "R7 no busy" : "R6 no busy", int'(busy), 0);
        end
        wp = 1'b0;
        ref_ptr = p;
    endtask

    task automatic do_read(input int n, input string req);
        send_cmd(1'b1, 1'b1);
        for (int i = 0; i < n; i++) read_one(req);
        send_stop(1'b0);
    endtask

    task automatic random_read(input logic [7:0] a, input int n, input string req);
        send_cmd(1'b0, 1'b1);
        send_byte(a);
        ref_ptr = a;
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
        chk(busy == 1'b0, "R11 no prog", int'(busy), 0);
        do_read(n, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        ref_ptr = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && cmd_ack == 1'b0 && rd_valid == 1'b0, "R1 reset outputs",
            int'({busy, cmd_ack, rd_valid}), 0);
        do_read(2, "R1 erased read from pointer 0");

        // R3 R10 page wrap from column 14
        do_write(8'h3E, 4, 1'b0, 1'b0);
        random_read(8'h30, 16, "R3 column wrap in row");
        // R10 pointer after write
        do_write(8'h52, 3, 1'b0, 1'b0);
        do_read(2, "R10 pointer after write");

        // R4 eighteen bytes overwrite, only loaded columns change
        do_write(8'h73, 18, 1'b0, 1'b0);
        random_read(8'h70, 16, "R4 rollover overwrite");
        do_write(8'h84, 2, 1'b0, 1'b0);
        random_read(8'h80, 16, "R4 unloaded bytes kept");

        // R6 stop with only an address
        do_write(8'h91, 0, 1'b0, 1'b0);
        do_read(1, "R6 pointer set, nothing programmed");
        random_read(8'h90, 3, "R6 array unchanged");

        // R7 write protect
        do_write(8'hA0, 5, 1'b1, 1'b0);
        random_read(8'hA0, 6, "R7 protected row unchanged");

        // R8 events during busy ignored
        do_write(8'hB2, 2, 1'b0, 1'b1);
        do_read(2, "R8 pointer unaffected by busy events");
        random_read(8'hB0, 6, "R8 array unaffected by busy events");

        // R9 read wrap 255 -> 0
        random_read(8'hFD, 5, "R9 read wrap");

        // R11 random read on written data
        random_read(8'h3E, 4, "R11 random read");

        // Random mix
        for (int t = 0; t < 40; t++) begin
            int kind = int'($urandom_range(0, 2));
            if (kind == 0)
                do_write(8'($urandom), int'($urandom_range(0, 20)),
                         ($urandom_range(0, 9) == 0), 1'b0);
            else if (kind == 1)
                random_read(8'($urandom), int'($urandom_range(1, 6)), "R9 random read");
            else
                do_read(int'($urandom_range(1, 4)), "R9 current read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule